// File: doc/BRIEF.md
# Integer-N Synthesizer Digital Core

This block holds the digital half of a two-divider integer-N frequency synthesizer. A 15-bit programmable counter divides the oscillator edge stream down to a divided-feedback strobe. A power-of-two counter divides the crystal edge stream down to a comparison strobe. A three-state phase/frequency detector compares the two strobes. Its result reaches the charge-pump control pins through a test-mode selector. That selector can also force the pump to sink or to source, turn it off, or release the tuning output.

Everything runs on one system clock. The oscillator and crystal edges arrive as single-cycle tick inputs. The register fields (divide ratio, reference code, mode, current select and lock threshold) are plain inputs driven by the control interface. A lock detector counts comparison periods in which neither detector output stays high for too long. It reports lock only in the normal, detector-driven mode.

Top module: `pll_synth_core`

## Requirements
- R1: After reset `f_div` and `f_comp` are low. Once running, `f_div` is a one-cycle pulse every `n_val` oscillator ticks.
- R2: An `n_val` below 64 divides by 64.
- R3: A new `n_val` is taken up only at the next terminal count. The interval already in progress finishes with the old ratio.
- R4: `ref_code` selects the reference ratio in crystal ticks: 000 gives 2, 001 gives 4, 010 gives 8, 011 gives 16 and 111 gives 32. After reset the ratio is 2.
- R5: Any other `ref_code` keeps the previous ratio and sets `ref_bad`. `ref_bad` stays set until reset.
- R6: The detector sets its up flop on `f_comp` and its down flop on `f_div`. When both would be set, both clear. `cp_up` and `cp_dn` are never high together.
- R7: `t_mode` 100 passes the detector outputs to the pump. 001 drives `cp_dn`=1, `cp_up`=0 and `vt_release`=1. 110 turns the pump off. 111 drives `cp_up`=1, `cp_dn`=0. Every other code turns the pump off. `vt_release` is high only in 001.
- R8: `cp_cur` always equals `c_sel`. The codes 00, 01, 10 and 11 select increasing current levels.
- R9: In mode 100, `lock` rises after 16 consecutive `f_comp` pulses with no violation. A violation is a detector output staying high for `lock_thresh` cycles.
- R10: A violation clears the lock state on the next clock.
- R11: Outside mode 100, `lock` is 0 and the count of good periods is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One pulse per oscillator edge |
| xtal_tick | input | 1 | One pulse per crystal edge |
| n_val | input | 15 | Main divide ratio |
| ref_code | input | 3 | Reference ratio code |
| t_mode | input | 3 | Pump/test mode |
| c_sel | input | 2 | Pump current select |
| lock_thresh | input | 8 | Pulse-width limit for lock, in cycles |
| f_div | output | 1 | Divided oscillator strobe |
| f_comp | output | 1 | Comparison strobe |
| cp_up | output | 1 | Pump source command |
| cp_dn | output | 1 | Pump sink command |
| cp_cur | output | 2 | Pump current level |
| vt_release | output | 1 | Tuning output released (high impedance) |
| lock | output | 1 | Loop locked flag |
| ref_bad | output | 1 | Sticky illegal reference code |

## Verification
The bench changes `n_val` partway through an interval. A design that reloads at once would cut that interval short and emit a runt pulse. It drives the ratio below 64, where a design without the floor divides too fast. It applies an illegal reference code and then a legal one. A design that decodes the bad code would change the comparison period, and one that does not hold the flag would drop `ref_bad`. For lock, it runs matched and then mismatched frequencies and leaves normal mode while locked. A design that ignores width violations would stay locked, and one that does not gate on mode would report lock in a test mode.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

    localparam int N_W          = 15;
    localparam int N_MIN        = 64;
    localparam int REF_LOG2_MAX = 5;
    localparam int REF_CW       = REF_LOG2_MAX + 1;
    localparam int LOCK_CYC     = 16;
    localparam int TH_W         = 8;

    typedef enum logic [2:0] {
        TM_SINK   = 3'b001,
        TM_NORMAL = 3'b100,
        TM_OFF    = 3'b110,
        TM_SOURCE = 3'b111
    } tmode_e;

    typedef struct packed {
        logic       ok;
        logic [2:0] lg;
    } ref_sel_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic rel;
    } cp_drive_t;

    function automatic ref_sel_t ref_decode(input logic [2:0] code);
        ref_sel_t s;
        s.ok = 1'b1;
        case (code)
            3'b000:  s.lg = 3'd1;
            3'b001:  s.lg = 3'd2;
            3'b010:  s.lg = 3'd3;
            3'b011:  s.lg = 3'd4;
            3'b111:  s.lg = 3'd5;
            default: begin s.ok = 1'b0; s.lg = 3'd0; end
        endcase
        return s;
    endfunction

    function automatic cp_drive_t mode_drive(input logic [2:0] m,
                                             input logic pu,
                                             input logic pd);
        cp_drive_t d;
        d = '0;
        case (m)
            TM_SINK:   begin d.dn = 1'b1; d.rel = 1'b1; end
            TM_NORMAL: begin d.up = pu;   d.dn = pd;    end
            TM_SOURCE: d.up = 1'b1;
            default:   d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pll_main_div.sv
module pll_main_div
    import pll_core_pkg::*;
#(
    parameter int NW   = N_W,
    parameter int NMIN = N_MIN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [NW-1:0] n_in,
    output logic          f_div
);
    logic [NW-1:0] cnt;
    logic [NW-1:0] n_eff;

    always_comb n_eff = (n_in < NW'(NMIN)) ? NW'(NMIN) : n_in;

    // the ratio is sampled only at terminal count, so no runt interval
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            f_div <= 1'b0;
        end else begin
            f_div <= 1'b0;
            if (tick) begin
                if (cnt < NW'(2)) begin
                    cnt   <= n_eff;
                    f_div <= 1'b1;
                end else begin
                    cnt <= cnt - NW'(1);
                end
            end
        end
    end

    AST_DIV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        f_div |=> !f_div); // R1
    AST_DIV_RELOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
        $rose(f_div) |-> (cnt >= NW'(NMIN))); // R2
endmodule

// File: rtl/pll_ref_div.sv
module pll_ref_div
    import pll_core_pkg::*;
#(
    parameter int CW = REF_CW
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [2:0] code,
    output logic       f_comp,
    output logic       bad
);
    ref_sel_t      sel;
    logic [2:0]    lg_q;
    logic [CW-1:0] cnt;

    always_comb sel = ref_decode(code);

    always_ff @(posedge clk) begin
        if (rst) begin
            lg_q   <= 3'd1;
            bad    <= 1'b0;
            cnt    <= '0;
            f_comp <= 1'b0;
        end else begin
            if (sel.ok) lg_q <= sel.lg;
            else        bad  <= 1'b1;
            f_comp <= 1'b0;
            if (tick) begin
                if (cnt < CW'(2)) begin
                    cnt    <= CW'(1) << lg_q;
                    f_comp <= 1'b1;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    AST_BAD_STICKY: assert property (@(posedge clk) disable iff (rst)
        bad |=> bad); // R5
    AST_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
        !sel.ok |=> $stable(lg_q)); // R5
    AST_COMP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        f_comp |=> !f_comp); // R4
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
    input  logic clk,
    input  logic rst,
    input  logic ref_p,
    input  logic div_p,
    output logic up_q,
    output logic dn_q
);
    logic up_n, dn_n;

    always_comb begin
        up_n = up_q | ref_p;
        dn_n = dn_q | div_p;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    AST_PFD_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (up_q && div_p) |=> (!up_q && !dn_q)); // R6
    AST_PFD_SET_UP: assert property (@(posedge clk) disable iff (rst)
        (ref_p && !div_p && !dn_q) |=> up_q); // R6
endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det
    import pll_core_pkg::*;
#(
    parameter int TW    = TH_W,
    parameter int NGOOD = LOCK_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up,
    input  logic          dn,
    input  logic          comp,
    input  logic          normal,
    input  logic [TW-1:0] thresh,
    output logic          lock_raw
);
    localparam int GCW = $clog2(NGOOD + 1);

    logic [TW-1:0]  wcnt;
    logic [TW:0]    wnext;
    logic [GCW-1:0] good;
    logic           active, viol;

    always_comb begin
        active = up | dn;
        wnext  = (TW+1)'(wcnt) + (TW+1)'(1);
        viol   = active && (wnext >= (TW+1)'(thresh));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt <= '0;
            good <= '0;
        end else begin
            if (!active)          wcnt <= '0;
            else if (wcnt != '1)  wcnt <= wcnt + TW'(1);
            if (!normal || viol)
                good <= '0;
            else if (comp && good != GCW'(NGOOD))
                good <= good + GCW'(1);
        end
    end

    always_comb lock_raw = (good == GCW'(NGOOD));

    AST_LOCK_VIOL: assert property (@(posedge clk) disable iff (rst)
        viol |=> !lock_raw); // R10
    AST_LOCK_STEP: assert property (@(posedge clk) disable iff (rst)
        $rose(lock_raw) |-> $past(comp)); // R9
    AST_LOCK_NORMAL_ONLY: assert property (@(posedge clk) disable iff (rst)
        !normal |=> !lock_raw); // R11
endmodule

// File: rtl/pll_synth_core.sv
module pll_synth_core
    import pll_core_pkg::*;
#(
    parameter int NW = N_W,
    parameter int TW = TH_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          osc_tick,
    input  logic          xtal_tick,
    input  logic [NW-1:0] n_val,
    input  logic [2:0]    ref_code,
    input  logic [2:0]    t_mode,
    input  logic [1:0]    c_sel,
    input  logic [TW-1:0] lock_thresh,
    output logic          f_div,
    output logic          f_comp,
    output logic          cp_up,
    output logic          cp_dn,
    output logic [1:0]    cp_cur,
    output logic          vt_release,
    output logic          lock,
    output logic          ref_bad
);
    logic      pfd_up, pfd_dn, lock_raw, normal;
    cp_drive_t drv;

    pll_main_div #(.NW(NW), .NMIN(N_MIN)) u_main (
        .clk(clk), .rst(rst), .tick(osc_tick), .n_in(n_val), .f_div(f_div)
    );

    pll_ref_div #(.CW(REF_CW)) u_ref (
        .clk(clk), .rst(rst), .tick(xtal_tick), .code(ref_code),
        .f_comp(f_comp), .bad(ref_bad)
    );

    pll_pfd u_pfd (
        .clk(clk), .rst(rst), .ref_p(f_comp), .div_p(f_div),
        .up_q(pfd_up), .dn_q(pfd_dn)
    );

    always_comb normal = (t_mode == TM_NORMAL);

    pll_lock_det #(.TW(TW), .NGOOD(LOCK_CYC)) u_lock (
        .clk(clk), .rst(rst), .up(pfd_up), .dn(pfd_dn), .comp(f_comp),
        .normal(normal), .thresh(lock_thresh), .lock_raw(lock_raw)
    );

    always_comb begin
        drv        = mode_drive(t_mode, pfd_up, pfd_dn);
        cp_up      = drv.up;
        cp_dn      = drv.dn;
        vt_release = drv.rel;
        cp_cur     = c_sel;
        lock       = lock_raw & normal;
    end

    AST_CP_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cp_up && cp_dn)); // R6
    AST_LOCK_MODE: assert property (@(posedge clk) disable iff (rst)
        lock |-> (t_mode == 3'b100)); // R11
    AST_RELEASE_SINK: assert property (@(posedge clk) disable iff (rst)
        vt_release |-> (t_mode == 3'b001 && cp_dn)); // R7
endmodule

// File: tb/pll_synth_core_tb.sv
module pll_synth_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0, xtal_tick = 1'b0;
    logic [14:0] n_val = 15'd100;
    logic [2:0]  ref_code = 3'b000;
    logic [2:0]  t_mode = 3'b001;
    logic [1:0]  c_sel = 2'b00;
    logic [7:0]  lock_thresh = 8'd127;
    logic        f_div, f_comp, cp_up, cp_dn, vt_release, lock, ref_bad;
    logic [1:0]  cp_cur;

    bit osc_en = 0, xtal_en = 0;
    int osc_every = 1, xtal_every = 1;
    int cyc = 0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pll_synth_core u_dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .xtal_tick(xtal_tick),
        .n_val(n_val), .ref_code(ref_code), .t_mode(t_mode), .c_sel(c_sel),
        .lock_thresh(lock_thresh), .f_div(f_div), .f_comp(f_comp),
        .cp_up(cp_up), .cp_dn(cp_dn), .cp_cur(cp_cur),
        .vt_release(vt_release), .lock(lock), .ref_bad(ref_bad)
    );

    always @(negedge clk) begin
        cyc       <= cyc + 1;
        osc_tick  <= osc_en  && (cyc % osc_every  == 0);
        xtal_tick <= xtal_en && (cyc % xtal_every == 0);
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pulse(input bit comp);
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if ((comp ? f_comp : f_div) == 1'b1) return;
        end
    endtask

    task automatic measure(input bit comp, output int p);
        wait_pulse(comp);
        p = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            p++;
            if ((comp ? f_comp : f_div) == 1'b1) return;
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cycles(3);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        t_mode = 3'b001; osc_en = 0; xtal_en = 0;
        do_reset();
        cycles(1);
        chk(f_div == 0 && f_comp == 0, "R1 reset strobes", {f_div, f_comp}, 0);
        chk(ref_bad == 0, "R5 reset flag", ref_bad, 0);
        chk(lock == 0, "R11 reset lock", lock, 0);
        chk({cp_up, cp_dn, vt_release} == 3'b011, "R7 sink at reset",
            {cp_up, cp_dn, vt_release}, 3);
    endtask

    task automatic t_main_period();
        int p;
        osc_en = 1; osc_every = 1;
        n_val = 15'd100;
        measure(0, p); measure(0, p);
        chk(p == 100, "R1 period N=100", p, 100);
        n_val = 15'd64;
        measure(0, p); measure(0, p);
        chk(p == 64, "R1 period N=64", p, 64);
        osc_every = 2;
        measure(0, p); measure(0, p);
        chk(p == 128, "R1 period counts ticks", p, 128);
        osc_every = 1;
        n_val = 15'd10;
        measure(0, p); measure(0, p);
        chk(p == 64, "R2 floor at 64", p, 64);
        n_val = 15'd0;
        measure(0, p); measure(0, p);
        chk(p == 64, "R2 zero ratio floor", p, 64);
    endtask

    task automatic t_main_change();
        int p;
        n_val = 15'd100;
        measure(0, p); measure(0, p);
        p = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            p++;
            if (p == 10) n_val = 15'd300;
            if (f_div) break;
        end
        chk(p == 100, "R3 interval in progress keeps old N", p, 100);
        p = 0;
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            p++;
            if (f_div) break;
        end
        chk(p == 300, "R3 next interval uses new N", p, 300);
        osc_en = 0;
    endtask

    task automatic t_ref();
        int p;
        logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b011, 3'b111};
        int         exps  [5] = '{2, 4, 8, 16, 32};
        xtal_en = 1; xtal_every = 1;
        for (int k = 0; k < 5; k++) begin
            ref_code = codes[k];
            measure(1, p); measure(1, p); measure(1, p);
            chk(p == exps[k], "R4 reference ratio", p, exps[k]);
        end
        chk(ref_bad == 0, "R5 legal codes leave flag low", ref_bad, 0);
        ref_code = 3'b100;
        measure(1, p); measure(1, p);
        chk(p == 32, "R5 illegal code keeps ratio", p, 32);
        chk(ref_bad == 1, "R5 illegal code flags", ref_bad, 1);
        ref_code = 3'b000;
        measure(1, p); measure(1, p); measure(1, p);
        chk(p == 2, "R4 legal code after illegal", p, 2);
        chk(ref_bad == 1, "R5 flag sticky", ref_bad, 1);
        xtal_en = 0;
    endtask

    task automatic t_pfd();
        t_mode = 3'b100;
        do_reset();
        n_val = 15'd64; ref_code = 3'b000;
        xtal_en = 1; xtal_every = 1; osc_en = 0;
        cycles(10);
        chk({cp_up, cp_dn} == 2'b10, "R6 reference lead drives up",
            {cp_up, cp_dn}, 2);
        xtal_en = 0; osc_en = 1; osc_every = 1;
        wait_pulse(0);
        cycles(3);
        chk({cp_up, cp_dn} == 2'b00, "R6 both set clears both",
            {cp_up, cp_dn}, 0);
        wait_pulse(0);
        cycles(3);
        chk({cp_up, cp_dn} == 2'b01, "R6 divider lead drives down",
            {cp_up, cp_dn}, 1);
        osc_en = 0;
    endtask

    task automatic t_modes();
        logic [2:0] m  [5] = '{3'b001, 3'b110, 3'b111, 3'b000, 3'b101};
        int         ex [5] = '{3, 0, 4, 0, 0};
        for (int k = 0; k < 5; k++) begin
            t_mode = m[k];
            cycles(1);
            chk({cp_up, cp_dn, vt_release} == 3'(ex[k]), "R7 mode drive",
                {cp_up, cp_dn, vt_release}, ex[k]);
        end
    endtask

    task automatic t_cur();
        for (int k = 0; k < 4; k++) begin
            c_sel = 2'(k);
            cycles(1);
            chk(cp_cur == 2'(k), "R8 current select", cp_cur, k);
        end
    endtask

    task automatic t_lock();
        int g;
        t_mode = 3'b100; n_val = 15'd64; ref_code = 3'b111;
        lock_thresh = 8'd127;
        osc_en = 0; xtal_en = 0;
        do_reset();
        osc_every = 1; xtal_every = 2;
        osc_en = 1; xtal_en = 1;
        cycles(800);
        chk(lock == 0, "R9 no lock before 16 periods", lock, 0);
        cycles(600);
        chk(lock == 1, "R9 lock after 16 good periods", lock, 1);
        t_mode = 3'b110;
        cycles(1);
        chk(lock == 0, "R11 lock gated off outside normal", lock, 0);
        cycles(2);
        t_mode = 3'b100;
        cycles(1);
        chk(lock == 0, "R11 good count cleared by mode change", lock, 0);
        cycles(1400);
        chk(lock == 1, "R9 relock in normal mode", lock, 1);
        n_val = 15'd200;
        for (g = 0; g < 3000; g++) begin
            @(negedge clk);
            if (!lock) break;
        end
        chk(lock == 0, "R10 violation drops lock", lock, 0);
        osc_en = 0; xtal_en = 0;
    endtask

    initial begin
        t_reset();
        t_main_period();
        t_main_change();
        t_ref();
        t_pfd();
        t_modes();
        t_cur();
        t_lock();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule